// File: doc/BRIEF.md
# Performance Monitor Control and Interrupt

This block holds the control and status state for a performance-monitor counter bank of up to 31 event counters (indices 0 to N-1) plus one cycle counter at fixed index 31. Software reaches it through a simple register port: a single-cycle write with address and data, and a combinational read selected by a read address. Counter enables, interrupt enables and overflow flags each have a separate set address and clear address. Writing a 1 to a bit acts on it, and writing a 0 leaves it alone.

The control register supplies the global enable and the two overflow-width selects to the counter bank. It also produces one-cycle reset strobes, one for the event counters and one for the cycle counter. These strobe bits are never stored. The counter bank reports wraps on an overflow-pulse input, and each pulse sets its overflow flag. A registered, level-sensitive interrupt is raised while any counter is overflowed, enabled and interrupt-enabled, provided the global enable is on.

No data stream passes through the block, so there is no valid/ready handshake. All pins are plain control or status signals, and no write can be back-pressured.

Top module: `pmu_ctl_irq`

## Requirements
- R1: The valid-counter mask is bit 31 plus bits N-1..0 (N = `NUM_CTR`), and only bit 31 when N is 0. Any register bit outside this mask reads 0, and writes to it are dropped.
- R2: Write address map: 0 control, 1 enable-set, 2 enable-clear, 3 irq-enable-set, 4 irq-enable-clear, 5 overflow-set, 6 overflow-clear. At a set address each data bit at 1 sets its flag, and at a clear address each data bit at 1 clears it. Data bits at 0 change nothing. A set address and its clear address read back the same register. Address 7 reads 0.
- R3: Control fields: bit 0 is the global enable and bit 6 is the long cycle-overflow select, both stored. Bits 15:11 read back N. `glb_en_o` and `long_cyc_o` follow the stored bits.
- R4: Control bits 1 (event-counter reset) and 2 (cycle-counter reset) always read as 0.
- R5: A control write with bit 1 set drives `ev_rst_o` to the event-counter part of the valid mask (bit 31 clear) for exactly the cycle after the write edge. At all other times `ev_rst_o` is 0.
- R6: A control write with bit 2 set drives `cyc_rst_o` high for exactly the cycle after the write edge.
- R7: Control bit 7 (long event-overflow select) is stored only when `HAS_LONG` is 1. Otherwise it stays 0, both on reads and on `long_ev_o`.
- R8: A bit of `ovf_pulse_i` that lies within the valid mask sets its overflow flag at the same edge. This wins over an overflow-clear write to that bit in the same cycle.
- R9: `irq_o` is a register. It takes the value E AND OR(overflow AND enable AND irq-enable) as computed from the register state of the previous cycle. It is 0 in the cycle after E is seen clear.
- R10: `irq_o` is a level, not a pulse. It stays high for as long as the condition persists, and it falls only once the condition goes away.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Write address |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 3 | Read address |
| rd_data_o | output | 32 | Read data (combinational) |
| ovf_pulse_i | input | 32 | Overflow pulses from the counter bank |
| cnt_en_o | output | 32 | Per-counter enable flags |
| glb_en_o | output | 1 | Global enable |
| long_cyc_o | output | 1 | Cycle counter overflows at 64 bits |
| long_ev_o | output | 1 | Event counters overflow at 64 bits |
| ev_rst_o | output | 32 | One-cycle event-counter reset strobe mask |
| cyc_rst_o | output | 1 | One-cycle cycle-counter reset strobe |
| irq_o | output | 1 | Overflow interrupt level |

## Verification
Register state, the control outputs and the reset strobes all change at the write edge, so the bench samples them shortly after that edge and reads the registers back within the same high phase. The interrupt trails the register state by one more edge. The bench therefore keeps the level it computed from the model before each update and compares `irq_o` against it one step later. A directed hold of several idle cycles shows the interrupt stays high as a level.

// File: rtl/pmu_ctl_pkg.sv
package pmu_ctl_pkg;

  typedef enum logic [2:0] {
    A_CTRL    = 3'd0,
    A_CEN_SET = 3'd1,
    A_CEN_CLR = 3'd2,
    A_IEN_SET = 3'd3,
    A_IEN_CLR = 3'd4,
    A_OVF_SET = 3'd5,
    A_OVF_CLR = 3'd6
  } reg_addr_e;

  localparam int CYC_IDX  = 31;
  localparam int CB_EN    = 0;
  localparam int CB_EVRST = 1;
  localparam int CB_CYRST = 2;
  localparam int CB_LCYC  = 6;
  localparam int CB_LEV   = 7;
  localparam int CB_NLO   = 11;

  function automatic logic [31:0] valid_mask(int n);
    logic [31:0] m;
    m = '0;
    for (int i = 0; i < CYC_IDX; i++) begin
      if (i < n) m[i] = 1'b1;
    end
    m[CYC_IDX] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/pmu_bitreg.sv
module pmu_bitreg #(
  parameter int          W     = 32,
  parameter logic [31:0] VALID = 32'h8000_0000
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  input  logic [W-1:0] hw_set_i,
  output logic [W-1:0] q_o
);
  localparam logic [W-1:0] VM = VALID[W-1:0];

  logic [W-1:0] q_d;

  always_comb q_d = ((q_o & ~clr_i) | set_i | hw_set_i) & VM;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= q_d;
  end

  // R1: no bit outside the valid mask is ever held
  a_r1_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_o & ~VM) == '0);

  // R8: a hardware set pulse is present at the next edge regardless of clears
  a_r8_hw_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((hw_set_i & VM) != '0) |=> ((q_o & $past(hw_set_i & VM)) == $past(hw_set_i & VM)));

endmodule

// File: rtl/pmu_ctlreg.sv
module pmu_ctlreg #(
  parameter int NUM_CTR  = 6,
  parameter bit HAS_LONG = 1'b0
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic        en_d_i,
  input  logic        evrst_d_i,
  input  logic        cyrst_d_i,
  input  logic        lcyc_d_i,
  input  logic        lev_d_i,
  output logic        en_o,
  output logic        lcyc_o,
  output logic        lev_o,
  output logic [31:0] ev_rst_o,
  output logic        cyc_rst_o,
  output logic [31:0] rd_o
);
  import pmu_ctl_pkg::*;

  localparam logic [31:0] EV_ONLY = valid_mask(NUM_CTR) & ~(32'd1 << CYC_IDX);
  localparam logic [4:0]  N_FLD   = 5'(NUM_CTR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o      <= 1'b0;
      lcyc_o    <= 1'b0;
      lev_o     <= 1'b0;
      ev_rst_o  <= '0;
      cyc_rst_o <= 1'b0;
    end else begin
      ev_rst_o  <= (wr_i && evrst_d_i) ? EV_ONLY : '0;
      cyc_rst_o <= wr_i && cyrst_d_i;
      if (wr_i) begin
        en_o   <= en_d_i;
        lcyc_o <= lcyc_d_i;
        lev_o  <= lev_d_i && HAS_LONG;
      end
    end
  end

  always_comb begin
    rd_o = '0;
    rd_o[CB_EN]              = en_o;
    rd_o[CB_LCYC]            = lcyc_o;
    rd_o[CB_LEV]             = lev_o;
    rd_o[CB_NLO+4:CB_NLO]    = N_FLD;
  end

  // R4: reset request bits never read back
  a_r4_rst_bits_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_o[CB_CYRST:CB_EVRST] == 2'b00);

  // R5: the event reset strobe never touches the cycle counter or an absent counter
  a_r5_strobe_scope: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_rst_o & ~EV_ONLY) == '0);

  // R5/R6: strobes last one cycle unless the control port is written again
  a_r6_one_shot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_rst_o && !wr_i) |=> !cyc_rst_o);

  generate
    if (!HAS_LONG) begin : g_no_long
      // R7: long event overflow unavailable
      a_r7_lev_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !lev_o);
    end
  endgenerate

endmodule

// File: rtl/pmu_irqgen.sv
module pmu_irqgen #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         glb_en_i,
  input  logic [W-1:0] ovf_i,
  input  logic [W-1:0] cen_i,
  input  logic [W-1:0] ien_i,
  output logic         irq_o
);
  logic lvl;

  always_comb lvl = glb_en_i && (|(ovf_i & cen_i & ien_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          irq_o <= 1'b0;
    else if (irq_o != lvl) irq_o <= lvl;
  end

  // R9: global enable off forces the line low one edge later
  a_r9_gated_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !glb_en_i |=> !irq_o);

  // R10: with no overflow flag set the line cannot rise
  a_r10_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_i == '0) |=> !irq_o);

endmodule

// File: rtl/pmu_ctl_irq.sv
module pmu_ctl_irq #(
  parameter int NUM_CTR  = 6,
  parameter bit HAS_LONG = 1'b0
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [2:0]  wr_addr_i,
  input  logic [31:0] wr_data_i,
  input  logic [2:0]  rd_addr_i,
  output logic [31:0] rd_data_o,
  input  logic [31:0] ovf_pulse_i,
  output logic [31:0] cnt_en_o,
  output logic        glb_en_o,
  output logic        long_cyc_o,
  output logic        long_ev_o,
  output logic [31:0] ev_rst_o,
  output logic        cyc_rst_o,
  output logic        irq_o
);
  import pmu_ctl_pkg::*;

  localparam int          W     = 32;
  localparam logic [31:0] VALID = valid_mask(NUM_CTR);
  localparam int          NREG  = 3;

  logic [W-1:0] set_v [NREG];
  logic [W-1:0] clr_v [NREG];
  logic [W-1:0] hw_v  [NREG];
  logic [W-1:0] q_v   [NREG];
  logic [31:0]  ctrl_rd;
  logic         wr_ctrl;

  always_comb wr_ctrl = wr_en_i && (wr_addr_i == A_CTRL);

  // index 0: counter enable, 1: interrupt enable, 2: overflow status
  generate
    for (genvar g = 0; g < NREG; g++) begin : g_reg
      localparam logic [2:0] SET_A = 3'(2*g + 1);
      localparam logic [2:0] CLR_A = 3'(2*g + 2);
      always_comb begin
        set_v[g] = (wr_en_i && wr_addr_i == SET_A) ? wr_data_i : '0;
        clr_v[g] = (wr_en_i && wr_addr_i == CLR_A) ? wr_data_i : '0;
        hw_v[g]  = (g == 2) ? ovf_pulse_i : '0;
      end
      pmu_bitreg #(.W(W), .VALID(VALID)) u_bits (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .set_i    (set_v[g]),
        .clr_i    (clr_v[g]),
        .hw_set_i (hw_v[g]),
        .q_o      (q_v[g])
      );
    end
  endgenerate

  pmu_ctlreg #(.NUM_CTR(NUM_CTR), .HAS_LONG(HAS_LONG)) u_ctl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr_ctrl),
    .en_d_i    (wr_data_i[CB_EN]),
    .evrst_d_i (wr_data_i[CB_EVRST]),
    .cyrst_d_i (wr_data_i[CB_CYRST]),
    .lcyc_d_i  (wr_data_i[CB_LCYC]),
    .lev_d_i   (wr_data_i[CB_LEV]),
    .en_o      (glb_en_o),
    .lcyc_o    (long_cyc_o),
    .lev_o     (long_ev_o),
    .ev_rst_o  (ev_rst_o),
    .cyc_rst_o (cyc_rst_o),
    .rd_o      (ctrl_rd)
  );

  pmu_irqgen #(.W(W)) u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .glb_en_i (glb_en_o),
    .ovf_i    (q_v[2]),
    .cen_i    (q_v[0]),
    .ien_i    (q_v[1]),
    .irq_o    (irq_o)
  );

  always_comb cnt_en_o = q_v[0];

  always_comb begin
    case (rd_addr_i)
      A_CTRL:               rd_data_o = ctrl_rd;
      A_CEN_SET, A_CEN_CLR: rd_data_o = q_v[0];
      A_IEN_SET, A_IEN_CLR: rd_data_o = q_v[1];
      A_OVF_SET, A_OVF_CLR: rd_data_o = q_v[2];
      default:              rd_data_o = '0;
    endcase
  end

endmodule

// File: tb/test_pmu_ctl_irq.sv
`timescale 1ns/100ps
module test_pmu_ctl_irq;
  localparam int NC = 6;
  localparam bit HL = 1'b0;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n;
  logic        wr_en;
  logic [2:0]  wr_addr;
  logic [31:0] wr_data;
  logic [2:0]  rd_addr;
  logic [31:0] rd_data;
  logic [31:0] ovf_pulse;
  logic [31:0] cnt_en;
  logic        glb_en, long_cyc, long_ev, cyc_rst, irq;
  logic [31:0] ev_rst;

  pmu_ctl_irq #(.NUM_CTR(NC), .HAS_LONG(HL)) i_pmu_ctl_irq (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .ovf_pulse_i(ovf_pulse), .cnt_en_o(cnt_en), .glb_en_o(glb_en),
    .long_cyc_o(long_cyc), .long_ev_o(long_ev), .ev_rst_o(ev_rst),
    .cyc_rst_o(cyc_rst), .irq_o(irq)
  );

  int n_vec = 0;
  int n_bad = 0;

  logic        m_e, m_lc, m_lp, m_cyr, m_irq;
  logic [31:0] m_cen, m_ien, m_ovf, m_evr;

  function automatic logic [31:0] vmask();
    logic [31:0] m = 32'h8000_0000;
    for (int i = 0; i < 31; i++) if (i < NC) m[i] = 1'b1;
    return m;
  endfunction

  function automatic logic [31:0] ctrl_exp();
    logic [31:0] r = '0;
    r[0] = m_e; r[6] = m_lc; r[7] = m_lp; r[15:11] = 5'(NC);
    return r;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all();
    chk("R9 irq", {31'd0, irq}, {31'd0, m_irq});
    chk("R5 ev_rst", ev_rst, m_evr);
    chk("R6 cyc_rst", {31'd0, cyc_rst}, {31'd0, m_cyr});
    chk("R3 glb_en", {31'd0, glb_en}, {31'd0, m_e});
    chk("R3 long_cyc", {31'd0, long_cyc}, {31'd0, m_lc});
    chk("R7 long_ev", {31'd0, long_ev}, {31'd0, m_lp});
    chk("R2 cnt_en", cnt_en, m_cen);
    rd_addr = 3'd0; #0.5; chk("R4 ctrl read", rd_data, ctrl_exp());
    rd_addr = 3'd2; #0.5; chk("R1 enable read", rd_data, m_cen);
    rd_addr = 3'd3; #0.5; chk("R2 irq-enable read", rd_data, m_ien);
    rd_addr = 3'd6; #0.5; chk("R8 overflow read", rd_data, m_ovf);
  endtask

  // called at a negedge; returns at the next negedge
  task automatic step(logic we, logic [2:0] a, logic [31:0] d, logic [31:0] p);
    logic [31:0] v;
    v = vmask();
    wr_en = we; wr_addr = a; wr_data = d; ovf_pulse = p;
    m_irq = m_e & (|(m_ovf & m_cen & m_ien));
    m_evr = '0; m_cyr = 1'b0;
    if (we) begin
      case (a)
        3'd0: begin
          m_e = d[0]; m_lc = d[6]; m_lp = d[7] & HL;
          m_evr = d[1] ? (v & 32'h7FFF_FFFF) : '0;
          m_cyr = d[2];
        end
        3'd1: m_cen = m_cen | (d & v);
        3'd2: m_cen = m_cen & ~d;
        3'd3: m_ien = m_ien | (d & v);
        3'd4: m_ien = m_ien & ~d;
        default: ;
      endcase
    end
    m_ovf = ((m_ovf & ~((we && a == 3'd6) ? d : 32'd0))
             | ((we && a == 3'd5) ? d : 32'd0) | p) & v;
    @(posedge clk);
    #1;
    check_all();
    @(negedge clk);
  endtask

  initial begin
    #1_600_000;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0; ovf_pulse = '0;
    m_e = 0; m_lc = 0; m_lp = 0; m_cyr = 0; m_irq = 0;
    m_cen = '0; m_ien = '0; m_ovf = '0; m_evr = '0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check_all(); // reset state, R3 count field
    rst_n = 1'b1;
    @(negedge clk);

    // R1: all-ones writes keep only valid bits
    step(1, 3'd1, 32'hFFFF_FFFF, 0);
    step(1, 3'd3, 32'hFFFF_FFFF, 0);
    // R2: zero bits leave state, one bits clear
    step(1, 3'd2, 32'h0000_0005, 0);
    step(1, 3'd1, 32'h0000_0000, 0);
    // R4/R5/R6/R7: reset bits, long selects
    step(1, 3'd0, 32'h0000_00C7, 0);
    step(0, 3'd0, 0, 0);
    step(1, 3'd0, 32'h0000_0001, 0);
    // R8: pulse beats same-cycle clear; out-of-range pulse dropped
    step(1, 3'd5, 32'h0000_0002, 0);
    step(1, 3'd6, 32'hFFFF_FFFF, 32'h8000_4002);
    // R10: hold the level across idle cycles
    for (int i = 0; i < 4; i++) step(0, 3'd7, 0, 0);
    chk("R10 irq held", {31'd0, irq}, 32'd1);
    // R9: global enable off drops it
    step(1, 3'd0, 32'h0000_0000, 0);
    step(0, 3'd7, 0, 0);
    chk("R9 irq gated", {31'd0, irq}, 32'd0);
    step(1, 3'd0, 32'h0000_0001, 0);
    step(1, 3'd6, 32'hFFFF_FFFF, 0);
    step(0, 3'd7, 0, 0);

    for (int i = 0; i < 600; i++) begin
      logic [31:0] d, p;
      d = ($urandom % 3 == 0) ? 32'hFFFF_FFFF : $urandom;
      p = ($urandom % 4 == 0) ? $urandom : 32'd0;
      step(($urandom % 5) != 0, 3'($urandom % 8), d, p);
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule